// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two N-bit operands over several clock cycles. The multiplier operand is scanned from its least significant end in overlapping windows of three bits: the two bits of the current pair, plus the upper bit of the pair below it. The bit below the lowest pair is taken as zero. Each window is recoded on the fly into a signed digit in {-2, -1, 0, +1, +2}. The digit value is x(low) + x(ref) - 2*x(high). The recoded digits are never stored. Each digit selects a multiple of the multiplicand, which is added to a running partial sum. The combined sum-and-multiplier register is then shifted right arithmetically by two places. Every step therefore has the same cost, and the number of steps depends only on the mode.

A caller waits for `ready`, presents the two operands and the mode, and pulses `start`. Signed (two's complement) operation takes N/2 steps. In unsigned operation both operands are extended internally with two zero bits, so the highest window always yields a non-negative digit, and one extra step is taken. The partial sum carries guard bits so that adding or subtracting twice the multiplicand cannot overflow. When the last step has been taken, `done` pulses for one cycle and `product` holds the 2N-bit result until the next accepted start. N must be even.

Top module: `booth4_seq_mult`

## Requirements
- R1: With `mode_signed`=1, `product` equals the two's complement product of `a_in` and `x_in`, given as 2N bits.
- R2: With `mode_signed`=0, `product` equals the unsigned product of `a_in` and `x_in`, given as 2N bits.
- R3: A start is accepted on a clock edge where `start`=1 and `ready`=1. `done` rises exactly N/2 cycles after that edge in signed mode, and exactly N/2+1 cycles after it in unsigned mode.
- R4: `done` is high for exactly one cycle. `product` stays unchanged from that cycle until the next accepted start.
- R5: `ready` is low from the cycle after an accepted start until `done` rises, and `ready` is high while `done` is high. A `start` seen while `ready`=0 is ignored: the running result and its timing are unchanged.
- R6: After reset, `ready`=1, `done`=0 and `product`=0.
- R7: Extreme operands give exact results. In signed mode these are the most negative values, for example -128 * -128 = 16384 for N=8. In unsigned mode these are all-ones values, for example 255*255 = 65025. The guard bits above the product are a clean sign or zero extension of it when `done` is high.
- R8: Multipliers with isolated ones, isolated zeros and long runs of ones all give correct products. For N=8 these are 0x55, 0xAA and 0xFF, which produce the digits +1, -2 and 0 in mixed sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; takes effect only while ready is high |
| mode_signed | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| a_in | input | N | Multiplicand |
| x_in | input | N | Multiplier (the recoded operand) |
| ready | output | 1 | High when idle and able to accept a start |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2N | Result; held until the next accepted start |

## Verification
Every cycle, the bound checker recomputes the expected product from the operands it captured when the start was accepted. It compares this against `product` whenever `done` is high. It also checks that the latency matches the mode, that `done` is a single pulse that only occurs with `ready` high, that the output holds steady while idle, and that the guard bits carry no overflow. Some behaviours can only be shown by the bench's directed scenarios. These are the reset values, a start raised in mid-run being ignored, and the coverage of particular digit patterns and extreme operands in both modes.

// File: rtl/booth4_pkg.sv
// Package: shared types for the radix-4 Booth multiplier.
// Assumes: nothing; holds only the recoded digit type.
package booth4_pkg;
    // Signed radix-4 digit chosen for one step
    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } digit_e;
endpackage

// File: rtl/booth4_recoder.sv
// Module: maps one overlapping 3-bit multiplier window to a signed digit.
// Assumes: win = {upper bit of pair, lower bit of pair, reference bit};
// digit value = lower + reference - 2*upper.
module booth4_recoder
    import booth4_pkg::*;
(
    input  logic [2:0] win,
    output digit_e     dig
);
    // Purpose: table decode of the window into a digit
    always_comb begin
        unique case (win)
            3'b001, 3'b010: dig = DIG_POS1;
            3'b011:         dig = DIG_POS2;
            3'b100:         dig = DIG_NEG2;
            3'b101, 3'b110: dig = DIG_NEG1;
            default:        dig = DIG_ZERO;
        endcase
    end
endmodule

// File: rtl/booth4_multiple.sv
// Module: forms the adder operand for one step from the multiplicand and the digit.
// Assumes: a_ext is already sign- or zero-extended to W bits; the output is W+2
// bits wide. A negative digit is produced by inversion plus carry-in of one.
module booth4_multiple
    import booth4_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0] a_ext,
    input  digit_e       dig,
    output logic [W+1:0] addend,
    output logic         cin
);
    logic [W+1:0] one_a;
    logic [W+1:0] two_a;

    // Purpose: widen A and 2A to the accumulator width
    always_comb begin
        one_a = {{2{a_ext[W-1]}}, a_ext};
        two_a = {a_ext[W-1], a_ext, 1'b0};
    end

    // Purpose: select the multiple and its polarity
    always_comb begin
        unique case (dig)
            DIG_POS1: begin addend = one_a;  cin = 1'b0; end
            DIG_POS2: begin addend = two_a;  cin = 1'b0; end
            DIG_NEG1: begin addend = ~one_a; cin = 1'b1; end
            DIG_NEG2: begin addend = ~two_a; cin = 1'b1; end
            default:  begin addend = '0;     cin = 1'b0; end
        endcase
    end
endmodule

// File: rtl/booth4_ctrl.sv
// Module: step sequencer. Accepts a start when idle, issues one step per
// cycle, and pulses done after the final step.
// Assumes: ext_mode is stable from the cycle after load until done.
module booth4_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ext_mode,
    output logic ready,
    output logic load,
    output logic step,
    output logic done
);
    localparam int HALF = N / 2;
    localparam int CW   = $clog2(HALF + 2);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_idx;

    // Purpose: index of the last step for the active mode
    always_comb begin
        last_idx = ext_mode ? CW'(HALF) : CW'(HALF - 1);
    end

    // Purpose: derived handshake and datapath strobes
    always_comb begin
        ready = !busy;
        load  = !busy && start;
        step  = busy;
    end

    // Purpose: busy flag, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == last_idx) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth4_seq_mult.sv
// Module: top of the sequential radix-4 Booth multiplier. Holds the partial
// sum (with two guard bits), the shifting multiplier, the reference bit and the
// captured multiplicand; one add/subtract and a 2-bit arithmetic shift per step.
// Assumes: N is even. Unsigned mode widens both operands by two zero bits.
module booth4_seq_mult
    import booth4_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           mode_signed,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   x_in,
    output logic           ready,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int W  = N + 2;
    localparam int HW = W + 2;
    localparam int RW = HW + W;

    logic [HW-1:0] hi_q;
    logic [W-1:0]  lo_q;
    logic [W-1:0]  a_q;
    logic          ref_q;
    logic          sgn_q;
    logic          load;
    logic          step;
    logic          a_fill;
    logic          x_fill;
    digit_e        dig;
    logic [HW-1:0] addend;
    logic          cin;
    logic [HW-1:0] sum;
    logic [RW-1:0] acc_full;

    booth4_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ext_mode (!sgn_q),
        .ready    (ready),
        .load     (load),
        .step     (step),
        .done     (done)
    );

    booth4_recoder u_rec (
        .win (({lo_q[1], lo_q[0], ref_q})),
        .dig (dig)
    );

    booth4_multiple #(.W(W)) u_mul (
        .a_ext  (a_q),
        .dig    (dig),
        .addend (addend),
        .cin    (cin)
    );

    // Purpose: fill bits for operand extension by mode
    always_comb begin
        a_fill = mode_signed & a_in[N-1];
        x_fill = mode_signed & x_in[N-1];
    end

    // Purpose: one add/subtract of the selected multiple
    always_comb begin
        sum = hi_q + addend + HW'(cin);
    end

    // Purpose: load operands, or take one step with a 2-bit arithmetic shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            a_q   <= '0;
            ref_q <= 1'b0;
            sgn_q <= 1'b0;
        end else if (load) begin
            hi_q  <= '0;
            lo_q  <= {{2{x_fill}}, x_in};
            a_q   <= {{2{a_fill}}, a_in};
            ref_q <= 1'b0;
            sgn_q <= mode_signed;
        end else if (step) begin
            hi_q  <= {sum[HW-1], sum[HW-1], sum[HW-1:2]};
            lo_q  <= {sum[1:0], lo_q[W-1:2]};
            ref_q <= lo_q[1];
        end
    end

    // Purpose: align the result window by the number of steps taken
    always_comb begin
        acc_full = {hi_q, lo_q};
        product  = sgn_q ? acc_full[2*N+1:2] : acc_full[2*N-1:0];
    end
endmodule

// File: rtl/booth4_seq_mult_chk.sv
// Module: assertion checker bound to booth4_seq_mult.
// Assumes: acc_full is the top's concatenated sum/multiplier register and
// sgn_q the mode captured at load.
module booth4_seq_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           mode_signed,
    input logic [N-1:0]   a_in,
    input logic [N-1:0]   x_in,
    input logic           ready,
    input logic           done,
    input logic [2*N-1:0] product,
    input logic [2*N+5:0] acc_full,
    input logic           sgn_q
);
    localparam int HALF = N / 2;

    logic [2*N-1:0] exp_q;
    logic           mode_c;
    logic           busy_c;
    logic [7:0]     cnt_c;
    logic [2*N-1:0] a_w;
    logic [2*N-1:0] x_w;
    logic [7:0]     lat_exp;

    // Purpose: operands widened per mode for the reference product
    always_comb begin
        a_w = mode_signed ? {{N{a_in[N-1]}}, a_in} : {{N{1'b0}}, a_in};
        x_w = mode_signed ? {{N{x_in[N-1]}}, x_in} : {{N{1'b0}}, x_in};
        lat_exp = mode_c ? 8'(HALF) : 8'(HALF + 1);
    end

    // Purpose: capture expectation and count cycles since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            mode_c <= 1'b0;
            busy_c <= 1'b0;
            cnt_c  <= '0;
        end else if (start && ready) begin
            exp_q  <= a_w * x_w;
            mode_c <= mode_signed;
            busy_c <= 1'b1;
            cnt_c  <= '0;
        end else begin
            if (busy_c) cnt_c <= cnt_c + 1'b1;
            if (done)   busy_c <= 1'b0;
        end
    end

    p_signed_prod_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_c) |-> product == exp_q);
    p_unsigned_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_c) |-> product == exp_q);
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_c && cnt_c == lat_exp));
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(product));
    p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);
    p_guard_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sgn_q ? (acc_full[2*N+5:2*N+1] == {5{acc_full[2*N+1]}})
                        : (acc_full[2*N+5:2*N] == 6'd0)));
endmodule

bind booth4_seq_mult booth4_seq_mult_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_signed (mode_signed),
    .a_in        (a_in),
    .x_in        (x_in),
    .ready       (ready),
    .done        (done),
    .product     (product),
    .acc_full    (acc_full),
    .sgn_q       (sgn_q)
);

// File: tb/booth4_seq_mult_bench.sv
// Bench: directed scenarios for booth4_seq_mult, one task per scenario.
module booth4_seq_mult_bench;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           mode_signed = 1'b0;
    logic [N-1:0]   a_in = '0;
    logic [N-1:0]   x_in = '0;
    logic           ready;
    logic           done;
    logic [2*N-1:0] product;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    booth4_seq_mult #(.N(N)) u_booth4_seq_mult (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_signed (mode_signed),
        .a_in        (a_in),
        .x_in        (x_in),
        .ready       (ready),
        .done        (done),
        .product     (product)
    );

    always #4 clk = ~clk;

    // Purpose: record one check
    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Purpose: reference product from the requirement
    function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a,
                                                input logic [N-1:0] x,
                                                input logic sgn);
        logic [2*N-1:0] aw;
        logic [2*N-1:0] xw;
        aw = sgn ? {{N{a[N-1]}}, a} : {{N{1'b0}}, a};
        xw = sgn ? {{N{x[N-1]}}, x} : {{N{1'b0}}, x};
        return aw * xw;
    endfunction

    // Purpose: scenario - reset state (R6)
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 ready", longint'(ready), 1);
        chk("R6 done", longint'(done), 0);
        chk("R6 product", longint'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Purpose: scenario - one multiplication with product, latency and pulse checks
    task automatic t_op(input string req, input logic [N-1:0] a,
                        input logic [N-1:0] x, input logic sgn);
        int cyc;
        logic [2*N-1:0] held;
        a_in = a; x_in = x; mode_signed = sgn; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " R3 latency"}, cyc, sgn ? N/2 : N/2 + 1);
        chk({req, " R1/R2 product"}, longint'(product), longint'(ref_prod(a, x, sgn)));
        chk({req, " R5 ready at done"}, longint'(ready), 1);
        held = product;
        @(negedge clk);
        chk({req, " R4 done pulse"}, longint'(done), 0);
        chk({req, " R4 hold"}, longint'(product), longint'(held));
    endtask

    // Purpose: scenario - start raised while busy is ignored (R5)
    task automatic t_busy_start();
        int cyc;
        a_in = 8'd13; x_in = 8'hF6; mode_signed = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R5 ready low while busy", longint'(ready), 0);
        a_in = 8'd99; x_in = 8'd77; mode_signed = 1'b0; start = 1'b1;
        cyc = 0;
        repeat (2) begin @(negedge clk); cyc++; end
        start = 1'b0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk("R5 busy start latency", cyc, N/2);
        chk("R5 busy start product", longint'(product),
            longint'(ref_prod(8'd13, 8'hF6, 1'b1)));
    endtask

    // Purpose: scenario - result held while idle for several cycles (R4)
    task automatic t_hold();
        logic [2*N-1:0] held;
        held = product;
        repeat (5) @(negedge clk);
        chk("R4 idle hold", longint'(product), longint'(held));
        chk("R4 no stray done", longint'(done), 0);
    endtask

    // Purpose: watchdog ends a hung run as a failure
    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_op("R1 7*-3",       8'd7,   8'hFD, 1'b1);
        t_op("R1 -1*-1",      8'hFF,  8'hFF, 1'b1);
        t_op("R1 zero",       8'd0,   8'h5A, 1'b1);
        t_op("R7 min*min",    8'h80,  8'h80, 1'b1);
        t_op("R7 min*max",    8'h80,  8'h7F, 1'b1);
        t_op("R8 s 0x55",     8'hB3,  8'h55, 1'b1);
        t_op("R8 s 0xAA",     8'h3C,  8'hAA, 1'b1);
        t_op("R2 200*3",      8'd200, 8'd3,  1'b0);
        t_op("R7 255*255",    8'hFF,  8'hFF, 1'b0);
        t_op("R8 u 0xAA",     8'h55,  8'hAA, 1'b0);
        t_op("R8 u 0x80",     8'd128, 8'h80, 1'b0);
        t_hold();
        t_busy_start();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule